// File: doc/BRIEF.md
# USB Charger Detection Sequencer

This block classifies a charger plugged into a USB receptacle and drives three indicator outputs. Its inputs are the results of analog comparators, presented as digital flags. They tell it that the bus supply is valid, that the data pins have made contact, what the primary and secondary handshakes found, and whether the data lines sit in either of two proprietary divider windows. A battery-good flag from the host system is the last input.

After the supply becomes valid, the sequencer waits for data contact, with a timeout. If contact arrives, it runs a debounce interval and then the primary and secondary comparisons, which yield one of three standard port classes. If the timeout expires first, it reads the window flags to pick a proprietary or low-current class. The class, together with the battery state, sets the charge-allowed output (active low, with the high-impedance state modelled as 1), the high-current flag and the data-switch control (active low: 0 closes the switch). If the battery stays flat while a charger is attached, a long timer withdraws charging. Only a fresh rising edge of battery-good starts detection again.

All intervals count pulses of a shared `tick_i` input, so the timebase can be scaled down.

Top module: `chgdet_seq`

## Requirements
- R1: After reset, and while the synchronized supply flag is low, the outputs hold the no-device encoding: chg_allow_n_o=1, chg_found_o=0, sw_open_n_o=1. Detection starts only after the supply flag goes high.
- R2: When vbus_ok_i falls, the outputs return to the no-device encoding within 4 clock edges. This covers the 2 synchronizer stages, the state register and the output register. It applies from any state.
- R3: If contact_i is seen during the contact wait, DEB_TICKS ticks of debounce follow. Then prim_chg_i=0 classifies the port as a standard data port. prim_chg_i=1 leads to the secondary check, where sec_dcp_i=1 gives a dedicated charger and 0 gives a charging data port.
- R4: If contact is not seen within DCD_TICKS ticks, the window flags decide the class. win_a_i=1 selects proprietary type A (this flag wins if both are set). Otherwise win_b_i=1 selects type B. With neither flag set, the class is the low-current non-compliant charger.
- R5: The outputs keep the no-device encoding until classification has finished.
- R6: For the standard and charging data ports, sw_open_n_o goes 0 only while the synchronized battery-good flag is 1. It returns to 1 when that flag is 0.
- R7: Once a class is known, chg_allow_n_o is 0 for every class. chg_found_o is 1 for the charging data port, the dedicated charger and both proprietary types. It is 0 for the standard data port and the low-current charger.
- R8: The dedicated charger, both proprietary types and the low-current charger keep sw_open_n_o=1 whatever the battery state.
- R9: While a class is held and battery-good is 0, a timer counts DBP_TICKS ticks. When it expires, the outputs return to the no-device encoding.
- R10: After expiry, only a 0-to-1 transition of battery-good restarts the full detection sequence. The same transition restarts the dead-battery timer from zero.
- R11: If battery-good rises before expiry, the timer is cleared. The switch output is re-evaluated for the class already held.
- R12: The contact timeout, the debounce and the dead-battery intervals advance only on clock edges where tick_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse; each high cycle advances the active interval |
| vbus_ok_i | input | 1 | Bus supply above its valid threshold |
| contact_i | input | 1 | Data pins have made contact |
| prim_chg_i | input | 1 | Primary result: 1 = charging-capable port, 0 = standard data port |
| sec_dcp_i | input | 1 | Secondary result: 1 = dedicated charger, 0 = charging data port |
| win_a_i | input | 1 | Data lines lie in proprietary window A |
| win_b_i | input | 1 | Data lines lie in proprietary window B |
| bat_good_i | input | 1 | Battery-good flag from the host |
| chg_allow_n_o | output | 1 | Charge allowed, active low; 1 models high impedance |
| chg_found_o | output | 1 | High-current charger detected |
| sw_open_n_o | output | 1 | Data switch control, 0 = closed |

## Verification
The dead-battery timer and the battery-driven switch decision both act on the same battery-good edge. A rise of battery-good in the cycle where the timer would expire must either cancel the count or re-arm detection, never both. The bench provokes this by lowering the battery flag on a charging data port for part of the interval, raising it, and lowering it again. It then expects the switch to follow the flag, with no expiry until a full uninterrupted interval has passed. A second case raises the flag after expiry and judges that detection reruns and that the next interval counts from zero.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DCD, ST_DEBOUNCE, ST_PRIMARY,
    ST_SECONDARY, ST_WINDOW, ST_DONE, ST_EXPIRED
  } seq_state_e;

  typedef enum logic [2:0] {
    PK_NONE, PK_SDP, PK_CDP, PK_DCP, PK_PROP_A, PK_PROP_B, PK_LOWCUR
  } port_kind_e;

  typedef struct packed {
    logic allow_n;
    logic found;
    logic sw_open_n;
  } pins_t;

  localparam pins_t PINS_NODEV = '{allow_n: 1'b1, found: 1'b0, sw_open_n: 1'b1};

  // Classes that may draw high current
  function automatic logic kind_high_current(port_kind_e k);
    return (k == PK_CDP) || (k == PK_DCP) || (k == PK_PROP_A) || (k == PK_PROP_B);
  endfunction

  // Classes that carry USB data traffic
  function automatic logic kind_data_port(port_kind_e k);
    return (k == PK_SDP) || (k == PK_CDP);
  endfunction

  function automatic pins_t encode_pins(logic done, port_kind_e k, logic bat);
    pins_t p;
    p = PINS_NODEV;
    if (done) begin
      p.allow_n   = 1'b0;
      p.found     = kind_high_current(k);
      p.sw_open_n = !(kind_data_port(k) && bat);
    end
    return p;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/chgdet_sync.sv
module chgdet_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/chgdet_ticker.sv
module chgdet_ticker #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [CW-1:0] limit_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (run_i && tick_i && (cnt_q < limit_i)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q >= limit_i);
endmodule

// File: rtl/chgdet_fsm.sv
module chgdet_fsm
  import chgdet_pkg::*;
#(
  parameter int CW     = 8,
  parameter int DCD_L  = 10,
  parameter int DEB_L  = 5,
  parameter int DBP_L  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vbus_s,
  input  logic          contact_s,
  input  logic          prim_s,
  input  logic          sec_s,
  input  logic          win_a_s,
  input  logic          win_b_s,
  input  logic          bat_s,
  input  logic          tmr_done,
  output logic          tmr_clr,
  output logic          tmr_run,
  output logic [CW-1:0] tmr_limit,
  output seq_state_e    state_o,
  output port_kind_e    kind_o,
  output logic          ev_dcd_timeout,
  output logic          ev_dbp_expire,
  output logic          ev_rearm
);
  localparam logic [CW-1:0] LIM_DCD = CW'(DCD_L);
  localparam logic [CW-1:0] LIM_DEB = CW'(DEB_L);
  localparam logic [CW-1:0] LIM_DBP = CW'(DBP_L);

  seq_state_e state_q, state_d;
  port_kind_e kind_q, kind_d;
  logic       bat_q;

  always_comb begin
    state_d        = state_q;
    kind_d         = kind_q;
    tmr_run        = 1'b0;
    tmr_limit      = LIM_DCD;
    ev_dcd_timeout = 1'b0;
    ev_dbp_expire  = 1'b0;
    ev_rearm       = 1'b0;
    if (!vbus_s) begin
      state_d = ST_IDLE;
      kind_d  = PK_NONE;
    end else begin
      case (state_q)
        ST_IDLE: state_d = ST_DCD;
        ST_DCD: begin
          tmr_limit = LIM_DCD;
          tmr_run   = 1'b1;
          if (contact_s) begin
            state_d = ST_DEBOUNCE;
          end else if (tmr_done) begin
            state_d        = ST_WINDOW;
            ev_dcd_timeout = 1'b1;
          end
        end
        ST_DEBOUNCE: begin
          tmr_limit = LIM_DEB;
          tmr_run   = 1'b1;
          if (tmr_done) state_d = ST_PRIMARY;
        end
        ST_PRIMARY: begin
          if (!prim_s) begin
            kind_d  = PK_SDP;
            state_d = ST_DONE;
          end else begin
            state_d = ST_SECONDARY;
          end
        end
        ST_SECONDARY: begin
          kind_d  = sec_s ? PK_DCP : PK_CDP;
          state_d = ST_DONE;
        end
        ST_WINDOW: begin
          if (win_a_s)      kind_d = PK_PROP_A;
          else if (win_b_s) kind_d = PK_PROP_B;
          else              kind_d = PK_LOWCUR;
          state_d = ST_DONE;
        end
        ST_DONE: begin
          tmr_limit = LIM_DBP;
          tmr_run   = !bat_s;
          if (!bat_s && tmr_done) begin
            state_d       = ST_EXPIRED;
            ev_dbp_expire = 1'b1;
          end
        end
        ST_EXPIRED: begin
          tmr_limit = LIM_DBP;
          if (bat_s && !bat_q) begin
            state_d  = ST_DCD;
            kind_d   = PK_NONE;
            ev_rearm = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // Any change of state restarts the shared interval; a good battery cancels the dead-battery count
  assign tmr_clr = (state_d != state_q) || ((state_q == ST_DONE) && bat_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= PK_NONE;
      bat_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      bat_q   <= bat_s;
    end
  end

  assign state_o = state_q;
  assign kind_o  = kind_q;
endmodule

// File: rtl/chgdet_encoder.sv
module chgdet_encoder
  import chgdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state_i,
  input  port_kind_e kind_i,
  input  logic       bat_s,
  output pins_t      pins_o
);
  pins_t pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= PINS_NODEV;
    else        pins_q <= encode_pins(state_i == ST_DONE, kind_i, bat_s);
  end

  assign pins_o = pins_q;
endmodule

// File: rtl/chgdet_seq.sv
module chgdet_seq
  import chgdet_pkg::*;
#(
  parameter int DCD_TICKS = 600,
  parameter int DEB_TICKS = 130,
  parameter int DBP_TICKS = 1800000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic vbus_ok_i,
  input  logic contact_i,
  input  logic prim_chg_i,
  input  logic sec_dcp_i,
  input  logic win_a_i,
  input  logic win_b_i,
  input  logic bat_good_i,
  output logic chg_allow_n_o,
  output logic chg_found_o,
  output logic sw_open_n_o
);
  localparam int NFLAG = 7;
  localparam int CW    = $clog2(max3(DCD_TICKS, DEB_TICKS, DBP_TICKS) + 1);

  logic [NFLAG-1:0] raw_flags, syn_flags;
  logic vbus_s, contact_s, prim_s, sec_s, win_a_s, win_b_s, bat_s;

  assign raw_flags = {vbus_ok_i, contact_i, prim_chg_i, sec_dcp_i, win_a_i, win_b_i, bat_good_i};

  chgdet_sync #(.W(NFLAG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_flags),
    .q_o   (syn_flags)
  );

  assign {vbus_s, contact_s, prim_s, sec_s, win_a_s, win_b_s, bat_s} = syn_flags;

  logic          tmr_clr, tmr_run, tmr_done;
  logic [CW-1:0] tmr_limit, tmr_cnt;
  seq_state_e    state_q;
  port_kind_e    kind_q;
  logic          ev_dcd_timeout, ev_dbp_expire, ev_rearm;
  pins_t         pins;

  chgdet_ticker #(.CW(CW)) u_ticker (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .clr_i   (tmr_clr),
    .run_i   (tmr_run),
    .limit_i (tmr_limit),
    .cnt_o   (tmr_cnt),
    .done_o  (tmr_done)
  );

  chgdet_fsm #(
    .CW    (CW),
    .DCD_L (DCD_TICKS),
    .DEB_L (DEB_TICKS),
    .DBP_L (DBP_TICKS)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .vbus_s         (vbus_s),
    .contact_s      (contact_s),
    .prim_s         (prim_s),
    .sec_s          (sec_s),
    .win_a_s        (win_a_s),
    .win_b_s        (win_b_s),
    .bat_s          (bat_s),
    .tmr_done       (tmr_done),
    .tmr_clr        (tmr_clr),
    .tmr_run        (tmr_run),
    .tmr_limit      (tmr_limit),
    .state_o        (state_q),
    .kind_o         (kind_q),
    .ev_dcd_timeout (ev_dcd_timeout),
    .ev_dbp_expire  (ev_dbp_expire),
    .ev_rearm       (ev_rearm)
  );

  chgdet_encoder u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (state_q),
    .kind_i  (kind_q),
    .bat_s   (bat_s),
    .pins_o  (pins)
  );

  assign chg_allow_n_o = pins.allow_n;
  assign chg_found_o   = pins.found;
  assign sw_open_n_o   = pins.sw_open_n;
endmodule

// File: rtl/chgdet_chk.sv
module chgdet_chk
  import chgdet_pkg::*;
#(
  parameter int CW    = 8,
  parameter int DCD_L = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          bat_s,
  input seq_state_e    state_q,
  input logic [CW-1:0] tmr_cnt,
  input logic          tmr_clr,
  input logic          ev_dcd_timeout,
  input logic          ev_dbp_expire,
  input logic          ev_rearm,
  input logic          chg_allow_n_o,
  input logic          chg_found_o,
  input logic          sw_open_n_o
);
  AST_IDLE_NODEV: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> (chg_allow_n_o && !chg_found_o && sw_open_n_o)); // R1
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_DONE) |=> (chg_allow_n_o && !chg_found_o && sw_open_n_o)); // R5
  AST_TIMEOUT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dcd_timeout |-> (tmr_cnt == CW'(DCD_L))); // R4
  AST_SWITCH_BAT: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_open_n_o |-> $past(bat_s)); // R6
  AST_FOUND_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    chg_found_o |-> !chg_allow_n_o); // R7
  AST_EXPIRE_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dbp_expire |-> !bat_s); // R9
  AST_REARM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rearm |-> (bat_s && !$past(bat_s))); // R10
  AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !tmr_clr) |=> $stable(tmr_cnt)); // R12
endmodule

bind chgdet_seq chgdet_chk #(.CW(CW), .DCD_L(DCD_TICKS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick_i         (tick_i),
  .bat_s          (bat_s),
  .state_q        (state_q),
  .tmr_cnt        (tmr_cnt),
  .tmr_clr        (tmr_clr),
  .ev_dcd_timeout (ev_dcd_timeout),
  .ev_dbp_expire  (ev_dbp_expire),
  .ev_rearm       (ev_rearm),
  .chg_allow_n_o  (chg_allow_n_o),
  .chg_found_o    (chg_found_o),
  .sw_open_n_o    (sw_open_n_o)
);

// File: tb/sim_chgdet_seq.sv
module sim_chgdet_seq;
  localparam int DCD = 20;
  localparam int DEB = 8;
  localparam int DBP = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic vbus = 0, contact = 0, prim = 0, sec = 0, wa = 0, wb = 0, bat = 0;
  logic allow_n, found, sw_n;

  always #2 clk = ~clk;

  chgdet_seq #(.DCD_TICKS(DCD), .DEB_TICKS(DEB), .DBP_TICKS(DBP)) u0 (
    .clk (clk), .rst_n (rst_n), .tick_i (tick), .vbus_ok_i (vbus),
    .contact_i (contact), .prim_chg_i (prim), .sec_dcp_i (sec),
    .win_a_i (wa), .win_b_i (wb), .bat_good_i (bat),
    .chg_allow_n_o (allow_n), .chg_found_o (found), .sw_open_n_o (sw_n)
  );

  typedef struct {
    logic [2:0] pins;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 0;

  localparam logic [2:0] NODEV = 3'b101;

  // Monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_cmp++;
        if ({allow_n, found, sw_n} !== e.pins) begin
          n_bad++;
          $display("FAIL %s: got allow_n/found/sw_n=%b expected %b", e.tag, {allow_n, found, sw_n}, e.pins);
        end
      end
    end
  end

  task automatic expect_pins(logic [2:0] p, string tag);
    exp_t e;
    e.pins = p;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic attach(logic c, logic p, logic s, logic a, logic b, logic g);
    contact = c; prim = p; sec = s; wa = a; wb = b; bat = g;
    vbus = 1'b1;
  endtask

  task automatic detach();
    vbus = 1'b0;
    cyc(4);
    expect_pins(NODEV, "R2 supply removed");
    cyc(4);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    expect_pins(NODEV, "R1 reset state");
    bat = 1'b1; contact = 1'b1;
    cyc(12);
    expect_pins(NODEV, "R1 no supply stays idle");

    // standard data port, good battery
    attach(1, 0, 0, 0, 0, 1);
    cyc(6);
    expect_pins(NODEV, "R5 detection running");
    cyc(34);
    expect_pins(3'b000, "R3 standard port switch closed");
    detach();

    // standard data port, flat battery, then expiry and re-arm
    attach(1, 0, 0, 0, 0, 0);
    cyc(40);
    expect_pins(3'b001, "R6 standard port flat battery");
    cyc(60);
    expect_pins(NODEV, "R9 dead-battery expiry");
    bat = 1'b1;
    cyc(40);
    expect_pins(3'b000, "R10 re-detect after rising edge");
    bat = 1'b0;
    cyc(25);
    expect_pins(3'b001, "R10 timer restarted from zero");
    cyc(40);
    expect_pins(NODEV, "R10 second expiry");
    detach();

    // charging data port, cancel of the timer
    attach(1, 1, 0, 0, 0, 1);
    cyc(40);
    expect_pins(3'b010, "R7 charging data port");
    bat = 1'b0;
    cyc(5);
    expect_pins(3'b011, "R6 switch opens on flat battery");
    cyc(20);
    bat = 1'b1;
    cyc(5);
    expect_pins(3'b010, "R11 switch re-evaluated");
    bat = 1'b0;
    cyc(30);
    expect_pins(3'b011, "R11 timer cancelled");
    cyc(30);
    expect_pins(NODEV, "R9 expiry after full interval");
    detach();

    // dedicated charger
    attach(1, 1, 1, 0, 0, 1);
    cyc(40);
    expect_pins(3'b011, "R8 dedicated charger switch open");
    detach();

    // timeout path, window A
    attach(0, 0, 0, 1, 0, 1);
    cyc(12);
    expect_pins(NODEV, "R5 contact wait running");
    cyc(40);
    expect_pins(3'b011, "R4 proprietary type A");
    detach();

    // timeout path, window B, flat battery
    attach(0, 0, 0, 0, 1, 0);
    cyc(50);
    expect_pins(3'b011, "R8 proprietary type B flat battery");
    detach();

    // both windows: A wins
    attach(0, 0, 0, 1, 1, 1);
    cyc(50);
    expect_pins(3'b011, "R4 window priority");
    detach();

    // open lines, low-current
    attach(0, 0, 0, 0, 0, 1);
    cyc(50);
    expect_pins(3'b001, "R4 low-current charger");
    detach();

    // intervals frozen without ticks
    tick = 1'b0;
    attach(0, 0, 0, 0, 0, 1);
    cyc(100);
    expect_pins(NODEV, "R12 no tick no timeout");
    tick = 1'b1;
    cyc(40);
    expect_pins(3'b001, "R12 timeout after ticks resume");
    detach();

    cyc(4);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule